// File: doc/BRIEF.md
# I2C Master Bit-Rate Generator

This block turns the system oscillator into the phase tick that an I2C master byte engine uses to shape its serial clock. A single 8-bit control register, written and read through a simple port, holds an enable bit, four general storage bits and a 3-bit rate code. The three rate bits are not adjacent: one sits at the top of the byte and two at the bottom. The byte engine that sits next to this block decodes the same byte, so the bit positions are fixed.

Seven of the eight rate codes pick a fixed oscillator divisor for one full SCL period. The irregular set includes a slow divide-by-960. The block emits four evenly spaced ticks per SCL period. The eighth code hands timing over to an external 8-bit auto-reload timer. Each overflow pulse of that timer advances the divider, and 24 overflows make one tick. With the timer overflowing every (256 − reload) clocks, one SCL period lasts 96 × (256 − reload) clocks. Divisors are applied as given. A code whose rate exceeds the bus limit at a fast oscillator is not clamped.

Top module: `sclk_rate_gen`

## Requirements
- R1: After reset the register reads 0x00, `enable` is low and `tick` is low.
- R2: A write stores the whole byte, and the next read returns it. Bit 6 is the enable and drives `enable`. Bits 5 down to 2 are plain storage with no effect on `tick`.
- R3: The rate code is {bit 7, bit 1, bit 0}, with bit 7 as its most significant bit.
- R4: With codes 0 to 6 and the block enabled, `tick` pulses every D/4 clocks. D is 256, 224, 192, 160, 960, 120 or 60 for codes 0, 1, 2, 3, 4, 5 and 6, so the tick intervals are 64, 56, 48, 40, 240, 30 and 15 clocks. No code is clamped.
- R5: With code 7, only clocks on which `tmr_ovf` is high advance the divider. `tick` pulses in the cycle after the 24th such overflow is sampled.
- R6: While the enable bit is 0, `tick` stays low and the divider is held at zero. Writing the enable bit to 1 starts the count from zero.
- R7: A write that changes the rate code, or that turns the block on, restarts the divider. The first tick is seen exactly one interval after the write edge.
- R8: A write that keeps the enable bit at 1 and leaves the rate code unchanged does not disturb the tick phase.
- R9: Each tick is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| tmr_ovf | input | 1 | Overflow pulse from the external auto-reload timer |
| rd_data | output | 8 | Register contents |
| enable | output | 1 | Enable bit of the register |
| tick | output | 1 | Phase tick, four per SCL period |

## Verification
A corrupted divider count or a wrong divisor shows at `tick` as a pulse that arrives early, late or not at all. For codes 0 to 6 this shows within one tick interval, at most 240 clocks. In timer mode it shows within 24 overflow pulses. A register bit stored at the wrong position appears on `rd_data` on the cycle after the write. It also changes the interval seen for the codes that use that bit. The reference model runs alongside the design on every clock. Any deviation is therefore caught on the first clock where `tick` or `rd_data` differs, and the directed interval counts name the requirement involved.

// File: rtl/sclk_rate_pkg.sv
package sclk_rate_pkg;

   // Control byte layout; positions are shared with the byte engine.
   typedef struct packed {
      logic rsel2;     // rate code bit 2
      logic en;        // block enable
      logic start_req; // storage
      logic stop_req;  // storage
      logic irq_flag;  // storage
      logic ack_en;    // storage
      logic rsel1;     // rate code bit 1
      logic rsel0;     // rate code bit 0
   } ctl_t;

   localparam int unsigned NUM_CODES  = 8;
   localparam logic [2:0]  TIMER_CODE = 3'd7;
   localparam int unsigned SLOWEST_DIV = 960;

   // Oscillator clocks per SCL period for the fixed codes.
   function automatic int unsigned base_divisor(input logic [2:0] code);
      case (code)
         3'd0:    return 256;
         3'd1:    return 224;
         3'd2:    return 192;
         3'd3:    return 160;
         3'd4:    return 960;
         3'd5:    return 120;
         3'd6:    return 60;
         default: return 0;
      endcase
   endfunction

   function automatic logic [2:0] rate_of(input ctl_t r);
      return {r.rsel2, r.rsel1, r.rsel0};
   endfunction

endpackage

// File: rtl/sclk_ctl_reg.sv
module sclk_ctl_reg
   import sclk_rate_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  ctl_t wr_data,
   output ctl_t q,
   output logic restart,
   output logic hold
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (wr_en) q <= wr_data;
   end

   // Restart when the block turns on, is written off, or changes its rate.
   always_comb begin
      restart = wr_en && (!wr_data.en || !q.en || (rate_of(wr_data) != rate_of(q)));
      hold    = !q.en;
   end

   // R2: a written byte is returned on the following cycle
   a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (q == $past(wr_data)));

   // R2: without a write the register keeps its value
   a_r2_retain: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(q));

endmodule

// File: rtl/sclk_rate_decode.sv
module sclk_rate_decode
   import sclk_rate_pkg::*;
#(
   parameter int unsigned PHASES       = 4,
   parameter int unsigned OVF_PER_TICK = 24,
   parameter int unsigned CNT_W        = 8
)(
   input  logic [2:0]       code,
   output logic [CNT_W-1:0] limit,
   output logic             timer_mode
);

   logic [CNT_W-1:0] lim_tab [NUM_CODES];

   for (genvar g = 0; g < NUM_CODES; g++) begin : g_code
      if (g == int'(TIMER_CODE)) begin : g_timer
         if (OVF_PER_TICK < 2 || OVF_PER_TICK >= (1 << CNT_W))
            $error("overflow count per tick out of range");
         assign lim_tab[g] = CNT_W'(OVF_PER_TICK);
      end else begin : g_fixed
         localparam int unsigned BASE = base_divisor(3'(g));
         localparam int unsigned LIM  = BASE / PHASES;
         if (LIM < 2 || LIM * PHASES != BASE)
            $error("divisor is not a multiple of the phase count");
         if (LIM >= (1 << CNT_W))
            $error("counter too narrow for divisor");
         assign lim_tab[g] = CNT_W'(LIM);
      end
   end

   assign limit      = lim_tab[code];
   assign timer_mode = (code == TIMER_CODE);

endmodule

// File: rtl/sclk_tick_div.sv
module sclk_tick_div #(
   parameter int unsigned CNT_W = 8
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             hold,
   input  logic             advance,
   input  logic [CNT_W-1:0] limit,
   output logic             tick
);

   logic [CNT_W-1:0] cnt;
   logic             at_end;

   assign at_end = (cnt == limit - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (restart || hold) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (advance) begin
         cnt  <= at_end ? '0 : cnt + 1'b1;
         tick <= at_end;
      end else begin
         tick <= 1'b0;
      end
   end

   // R9: ticks are one cycle wide
   a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

   // R6: a disabled block holds the divider at zero
   a_r6_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !restart) |=> (cnt == '0 && !tick));

   // R7: a restart clears the divider phase
   a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt == '0 && !tick));

   // R5: without an advance the count stands still and no tick appears
   a_r5_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (!advance && !restart && !hold) |=> ($stable(cnt) && !tick));

   // R4: the count never reaches the selected interval
   a_r4_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < limit);

endmodule

// File: rtl/sclk_rate_gen.sv
module sclk_rate_gen
   import sclk_rate_pkg::*;
#(
   parameter int unsigned PHASES       = 4,
   parameter int unsigned OVF_PER_TICK = 24
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] wr_data,
   input  logic       tmr_ovf,
   output logic [7:0] rd_data,
   output logic       enable,
   output logic       tick
);

   localparam int unsigned FIX_MAX = SLOWEST_DIV / PHASES;
   localparam int unsigned MAX_LIM = (FIX_MAX > OVF_PER_TICK) ? FIX_MAX : OVF_PER_TICK;
   localparam int unsigned CNT_W   = $clog2(MAX_LIM);

   if (PHASES < 1) begin : g_chk_phases
      $error("phase count must be positive");
   end

   ctl_t             ctl_q;
   logic             restart, hold, timer_mode, advance;
   logic [CNT_W-1:0] limit;

   sclk_ctl_reg u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (ctl_t'(wr_data)),
      .q       (ctl_q),
      .restart (restart),
      .hold    (hold)
   );

   sclk_rate_decode #(
      .PHASES       (PHASES),
      .OVF_PER_TICK (OVF_PER_TICK),
      .CNT_W        (CNT_W)
   ) u_decode (
      .code       (rate_of(ctl_q)),
      .limit      (limit),
      .timer_mode (timer_mode)
   );

   assign advance = timer_mode ? tmr_ovf : 1'b1;

   sclk_tick_div #(.CNT_W(CNT_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .hold    (hold),
      .advance (advance),
      .limit   (limit),
      .tick    (tick)
   );

   assign rd_data = ctl_q;
   assign enable  = ctl_q.en;

   // R6: no tick while the enable bit reads 0
   a_r6_tick_off: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> !tick);

endmodule

// File: tb/sclk_rate_gen_tb.sv
module sclk_rate_gen_tb;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       tmr_ovf = 1'b0;
   logic [7:0] rd_data;
   logic       enable;
   logic       tick;

   int checks = 0;
   int fails  = 0;
   bit run    = 0;
   string phase = "R1";

   always #(CLK_PERIOD/2) clk = ~clk;

   sclk_rate_gen u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .tmr_ovf(tmr_ovf), .rd_data(rd_data), .enable(enable), .tick(tick)
   );

   // Ticks between pulses per code, taken from the requirements.
   function automatic int interval(input int code);
      case (code)
         0: return 64;  1: return 56;  2: return 48;  3: return 40;
         4: return 240; 5: return 30;  6: return 15;  default: return 24;
      endcase
   endfunction

   function automatic int code_of(input int r);
      return ((r >> 5) & 4) | (r & 3);
   endfunction

   function automatic logic [7:0] ctl(input int code, input bit en, input int store);
      return {code[2], en, store[3:0], code[1:0]};
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic summary;
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   // Reference model, updated at each rising edge from the driven inputs.
   int m_reg = 0, m_cnt = 0, m_tick = 0;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_reg = 0; m_cnt = 0; m_tick = 0;
      end else begin
         bit restart_m;
         restart_m = 0;
         if (wr_en) begin
            restart_m = !wr_data[6] || !m_reg[6] || (code_of(wr_data) != code_of(m_reg));
            m_reg = wr_data;
         end
         if (restart_m || !m_reg[6]) begin
            m_cnt = 0; m_tick = 0;
         end else begin
            m_tick = 0;
            if (code_of(m_reg) != 7 || tmr_ovf) begin
               m_cnt++;
               if (m_cnt == interval(code_of(m_reg))) begin
                  m_cnt = 0; m_tick = 1;
               end
            end
         end
      end
   end

   always @(negedge clk) begin
      if (run) begin
         chk(tick === m_tick[0], {phase, " tick vs model"}, int'(tick), m_tick);
         chk(rd_data === m_reg[7:0], {phase, " register vs model"}, int'(rd_data), m_reg);
      end
   end

   task automatic write(input logic [7:0] d);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // Count negedges until a tick shows; start counts negedges already elapsed.
   task automatic wait_tick(input int start, input int exp, input string tag);
      int n = start;
      do begin
         @(negedge clk); n++;
      end while (!tick && n < 2000);
      chk(n == exp, {tag, " tick interval"}, n, exp);
      @(negedge clk);
      chk(!tick, "R9 single-cycle tick", int'(tick), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk(rd_data == 8'h00, "R1 reset register", int'(rd_data), 0);
      chk(!enable, "R1 reset enable", int'(enable), 0);
      chk(!tick, "R1 reset tick", int'(tick), 0);
      run = 1;

      // R4 and R3: every fixed code, split rate bits
      phase = "R4";
      for (int c = 0; c < 7; c++) begin
         write(ctl(c, 1, 0));
         chk(rd_data == ctl(c, 1, 0), "R3 code bits stored", int'(rd_data), int'(ctl(c, 1, 0)));
         wait_tick(0, interval(c), "R4 first");
         wait_tick(1, interval(c), "R4 period");
      end

      // R2: storage bits read back and leave the interval unchanged
      phase = "R2";
      write(ctl(0, 1, 4'hF));
      chk(rd_data == 8'h7C, "R2 readback", int'(rd_data), 8'h7C);
      chk(enable, "R2 enable bit", int'(enable), 1);
      wait_tick(0, 64, "R2 storage bits ignored");

      // R8: same-rate write while enabled keeps phase
      phase = "R8";
      write(ctl(2, 1, 0));
      repeat (10) @(negedge clk);
      write(ctl(2, 1, 4'hA));
      wait_tick(11, 48, "R8 phase kept");

      // R7: rate change restarts
      phase = "R7";
      repeat (7) @(negedge clk);
      write(ctl(6, 1, 0));
      wait_tick(0, 15, "R7 restart on rate change");

      // R6: disabled holds off ticks; re-enable counts from zero
      phase = "R6";
      write(ctl(1, 0, 0));
      chk(!enable, "R6 enable low", int'(enable), 0);
      begin
         int seen = 0;
         repeat (200) begin
            @(negedge clk);
            if (tick) seen++;
         end
         chk(seen == 0, "R6 no tick while off", seen, 0);
      end
      write(ctl(1, 1, 0));
      wait_tick(0, 56, "R6 re-enable from zero");

      // R5: timer-overflow mode with sparse then continuous pulses
      phase = "R5";
      for (int mode = 0; mode < 2; mode++) begin
         int ovf_cnt = 0, n = 0;
         bit seen = 0;
         write(ctl(7, 1, 0));
         while (!seen && n < 500) begin
            @(negedge clk); n++;
            if (tick) seen = 1;
            else begin
               tmr_ovf = (mode == 1) || (n % 3 == 0);
               if (tmr_ovf) ovf_cnt++;
            end
         end
         tmr_ovf = 1'b0;
         chk(ovf_cnt == 24, "R5 overflows per tick", ovf_cnt, 24);
         repeat (5) @(negedge clk);
         chk(!tick, "R5 no tick without overflow", int'(tick), 0);
      end

      repeat (3) @(negedge clk);
      summary();
      $finish;
   end

endmodule